// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block stands between a pair of PWM output channels and their pads and forces them to programmed safe levels when a fault is reported. Five hardware fault sources feed it: two comparator outputs, two external brake pins and a combined system-fail signal. A software brake request can be added as well. Every source has two independent enables. One arms it as a latching edge brake, and the other arms it as a self-releasing level brake.

The two brake pins each pass through a selectable polarity inversion and then a sample-count noise filter. The filter samples on a tick taken from the system clock divided by a power of two. The system-fail signal is the OR of four monitor inputs: clock fail, brown-out, memory parity and core lockup. Each monitor input has its own enable. A state machine holds the brake condition and has four states. In RUN the outputs follow their inputs. In LEVEL_HOLD a level brake is in force. In LEVEL_WAIT the level source has gone quiet and the block waits for the next period boundary. In EDGE_LATCH an edge brake is held until software releases it. The transitions are:
- RUN to LEVEL_HOLD on level activity.
- Any state to EDGE_LATCH on an edge hit.
- LEVEL_HOLD to LEVEL_WAIT when the level source drops.
- LEVEL_WAIT back to LEVEL_HOLD when the level source returns.
- LEVEL_WAIT to RUN on a period boundary.
- EDGE_LATCH to LEVEL_HOLD or RUN on release, depending on whether level activity is still present.

Two sticky interrupt flags, one for edge brakes and one for level brakes, report each new trigger.

Top module: `pwm_brake_ctrl`

## Requirements
- R1: Source bit order in `edge_en` and `level_en` is bit0 comparator 0, bit1 comparator 1, bit2 pin 0, bit3 pin 1, bit4 system fail. A rising edge of an edge-enabled source forces the outputs safe from the next clock edge. The brake stays in force after the source returns low.
- R2: An edge brake ends only on the clock edge after `edge_release` is high. If a new edge hit arrives in the same cycle as the release, the brake stays in force.
- R3: A level-enabled source forces the outputs safe while it is active. After it drops, the outputs stay safe until a cycle in which `period_end` is high, and they pass through from the clock edge that ends that cycle.
- R4: If the level source returns while waiting for the period boundary, a following `period_end` does not release the brake.
- R5: System fail is the OR of `sys_fail_in[i] & sys_fail_en[i]`. The bit order is 0 clock fail, 1 brown-out, 2 memory parity, 3 core lockup. A disabled monitor input has no effect.
- R6: A pulse on `sw_edge_req` latches an edge brake. Holding `sw_level_req` high acts as a level brake.
- R7: When `pin_inv[i]` is 1, pin i is active low before the filter.
- R8: A pin level change passes the filter after `nf_count` consecutive differing samples, where a count of 0 acts as 1. With a divider of 1, a pin brake applies nf_count+1 clock edges after the pin changes. A shorter pulse is ignored.
- R9: The filter samples once every 2^`nf_div` clocks.
- R10: `irq_flags[0]` sets on any edge hit and `irq_flags[1]` on each new onset of level activity. `irq_ack[i]` clears flag i, and a set in the same cycle wins.
- R11: During a brake, `pwm_out[i]` equals `safe_lvl[i]`. Otherwise it equals `pwm_in[i]`, which is the final output after inversion.
- R12: After reset the controller is in RUN, the outputs pass through, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 2 | Comparator outputs, active high |
| pin_raw | input | 2 | External brake pins |
| pin_inv | input | 2 | Per-pin polarity inversion |
| nf_div | input | 3 | Filter sample divider code (2^code) |
| nf_count | input | 4 | Required consecutive samples |
| sys_fail_in | input | 4 | System monitor fault inputs |
| sys_fail_en | input | 4 | Enables for the monitor inputs |
| sw_edge_req | input | 1 | Software edge brake pulse |
| sw_level_req | input | 1 | Software level brake request |
| edge_en | input | 5 | Edge-brake enables per source |
| level_en | input | 5 | Level-brake enables per source |
| edge_release | input | 1 | Software release of an edge brake |
| period_end | input | 1 | PWM period boundary pulse |
| irq_ack | input | 2 | Flag clears (0 edge, 1 level) |
| safe_lvl | input | 2 | Safe level per channel |
| pwm_in | input | 2 | Final PWM levels after inversion |
| pwm_out | output | 2 | Gated PWM outputs |
| brake_active | output | 1 | High while any brake is in force |
| irq_flags | output | 2 | Sticky flags (0 edge, 1 level) |

## Verification
A software release and a fresh edge hit can arrive in the same cycle. The bench provokes this by raising `edge_release` and `sw_edge_req` together while the brake is latched, and it passes only if the outputs stay at the safe levels afterwards. The same clash occurs on the interrupt flags. The bench pulses `irq_ack[0]` in the cycle of a new edge hit and expects the flag to remain set.

// File: rtl/pwm_brake_pkg.sv
package pwm_brake_pkg;
    localparam int NUM_SRC  = 5;
    localparam int SRC_CMP0 = 0;
    localparam int SRC_CMP1 = 1;
    localparam int SRC_PIN0 = 2;
    localparam int SRC_PIN1 = 3;
    localparam int SRC_SYS  = 4;

    typedef enum logic [1:0] {
        ST_RUN        = 2'd0,
        ST_LEVEL_HOLD = 2'd1,
        ST_LEVEL_WAIT = 2'd2,
        ST_EDGE_LATCH = 2'd3
    } brake_state_e;
endpackage

// File: rtl/brake_tick_gen.sv
module brake_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_cnt <= '0;
        end else begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

    always_comb begin
        mask = (CNT_W'(1) << div_code) - CNT_W'(1);
        tick = ((free_cnt & mask) == mask);
    end
endmodule

// File: rtl/brake_pin_filter.sv
module brake_pin_filter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             raw,
    input  logic             invert,
    input  logic [CNT_W-1:0] need_cnt,
    output logic             filt
);
    logic             sample;
    logic [CNT_W:0]   need;
    logic [CNT_W-1:0] run_cnt;
    logic             filt_q;

    always_comb begin
        sample = raw ^ invert;
        need   = (need_cnt == '0) ? (CNT_W+1)'(1) : {1'b0, need_cnt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q  <= 1'b0;
            run_cnt <= '0;
        end else if (tick) begin
            if (sample == filt_q) begin
                run_cnt <= '0;
            end else if (({1'b0, run_cnt} + (CNT_W+1)'(1)) >= need) begin
                filt_q  <= sample;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign filt = filt_q;

    AST_FILT_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(filt_q)); // R9
endmodule

// File: rtl/brake_fsm.sv
module brake_fsm
    import pwm_brake_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_hit,
    input  logic              lvl_act,
    input  logic              edge_release,
    input  logic              period_end,
    input  logic [1:0]        irq_ack,
    input  logic [NUM_CH-1:0] safe_lvl,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              brake_active,
    output logic [1:0]        irq_flags
);
    brake_state_e state_q, state_d;
    logic         lvl_q;
    logic [1:0]   flags_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (edge_hit)     state_d = ST_EDGE_LATCH;
                else if (lvl_act) state_d = ST_LEVEL_HOLD;
            end
            ST_LEVEL_HOLD: begin
                if (edge_hit)      state_d = ST_EDGE_LATCH;
                else if (!lvl_act) state_d = ST_LEVEL_WAIT;
            end
            ST_LEVEL_WAIT: begin
                if (edge_hit)        state_d = ST_EDGE_LATCH;
                else if (lvl_act)    state_d = ST_LEVEL_HOLD;
                else if (period_end) state_d = ST_RUN;
            end
            ST_EDGE_LATCH: begin
                if (edge_release && !edge_hit)
                    state_d = lvl_act ? ST_LEVEL_HOLD : ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= 1'b0;
            flags_q <= 2'b00;
        end else begin
            lvl_q <= lvl_act;
            flags_q[0] <= edge_hit | (flags_q[0] & ~irq_ack[0]);
            flags_q[1] <= (lvl_act & ~lvl_q) | (flags_q[1] & ~irq_ack[1]);
        end
    end

    always_comb begin
        brake_active = (state_q != ST_RUN);
        pwm_out      = brake_active ? safe_lvl : pwm_in;
        irq_flags    = flags_q;
    end

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EDGE_LATCH && !edge_release) |=> (state_q == ST_EDGE_LATCH)); // R2
    AST_RELEASE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && edge_release) |=> brake_active); // R2
    AST_WAIT_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEVEL_WAIT && !period_end) |=> brake_active); // R3
    AST_EDGE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> irq_flags[0]); // R10
endmodule

// File: rtl/pwm_brake_ctrl.sv
module pwm_brake_ctrl
    import pwm_brake_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int NUM_PIN = 2,
    parameter int NUM_CMP = 2,
    parameter int NUM_SYS = 4,
    parameter int DIV_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_in,
    input  logic [NUM_PIN-1:0] pin_raw,
    input  logic [NUM_PIN-1:0] pin_inv,
    input  logic [DIV_W-1:0]   nf_div,
    input  logic [CNT_W-1:0]   nf_count,
    input  logic [NUM_SYS-1:0] sys_fail_in,
    input  logic [NUM_SYS-1:0] sys_fail_en,
    input  logic               sw_edge_req,
    input  logic               sw_level_req,
    input  logic [NUM_SRC-1:0] edge_en,
    input  logic [NUM_SRC-1:0] level_en,
    input  logic               edge_release,
    input  logic               period_end,
    input  logic [1:0]         irq_ack,
    input  logic [NUM_CH-1:0]  safe_lvl,
    input  logic [NUM_CH-1:0]  pwm_in,
    output logic [NUM_CH-1:0]  pwm_out,
    output logic               brake_active,
    output logic [1:0]         irq_flags
);
    logic               tick;
    logic [NUM_PIN-1:0] pin_filt;
    logic [NUM_SRC-1:0] src_now;
    logic [NUM_SRC-1:0] src_q;
    logic               sys_fail;
    logic               edge_hit;
    logic               lvl_act;

    brake_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_code(nf_div),
        .tick    (tick)
    );

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        brake_pin_filter #(.CNT_W(CNT_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .raw     (pin_raw[p]),
            .invert  (pin_inv[p]),
            .need_cnt(nf_count),
            .filt    (pin_filt[p])
        );
    end

    always_comb begin
        sys_fail = |(sys_fail_in & sys_fail_en);
        src_now  = '0;
        src_now[SRC_CMP0] = cmp_in[0];
        src_now[SRC_CMP1] = cmp_in[1];
        src_now[SRC_PIN0] = pin_filt[0];
        src_now[SRC_PIN1] = pin_filt[1];
        src_now[SRC_SYS]  = sys_fail;
        edge_hit = (|(edge_en & src_now & ~src_q)) | sw_edge_req;
        lvl_act  = (|(level_en & src_now)) | sw_level_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else begin
            src_q <= src_now;
        end
    end

    brake_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_hit    (edge_hit),
        .lvl_act     (lvl_act),
        .edge_release(edge_release),
        .period_end  (period_end),
        .irq_ack     (irq_ack),
        .safe_lvl    (safe_lvl),
        .pwm_in      (pwm_in),
        .pwm_out     (pwm_out),
        .brake_active(brake_active),
        .irq_flags   (irq_flags)
    );

    AST_SYS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((sys_fail_in & sys_fail_en) == '0 && level_en == 5'b10000 && edge_en == '0
         && !sw_level_req && !sw_edge_req && !brake_active) |=> !brake_active); // R5
endmodule

// File: tb/pwm_brake_ctrl_tb_top.sv
module pwm_brake_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_in = '0, pin_raw = '0, pin_inv = '0;
    logic [2:0] nf_div = '0;
    logic [3:0] nf_count = 4'd3;
    logic [3:0] sys_fail_in = '0, sys_fail_en = '0;
    logic       sw_edge_req = 1'b0, sw_level_req = 1'b0;
    logic [4:0] edge_en = '0, level_en = '0;
    logic       edge_release = 1'b0, period_end = 1'b0;
    logic [1:0] irq_ack = '0;
    logic [1:0] safe_lvl = 2'b10, pwm_in = 2'b01;
    logic [1:0] pwm_out, irq_flags;
    logic       brake_active;
    int n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    pwm_brake_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .pin_raw(pin_raw), .pin_inv(pin_inv),
        .nf_div(nf_div), .nf_count(nf_count), .sys_fail_in(sys_fail_in),
        .sys_fail_en(sys_fail_en), .sw_edge_req(sw_edge_req), .sw_level_req(sw_level_req),
        .edge_en(edge_en), .level_en(level_en), .edge_release(edge_release),
        .period_end(period_end), .irq_ack(irq_ack), .safe_lvl(safe_lvl), .pwm_in(pwm_in),
        .pwm_out(pwm_out), .brake_active(brake_active), .irq_flags(irq_flags)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic braked(input string req, input bit on);
        chk(req, pwm_out, on ? safe_lvl : pwm_in);
    endtask

    task automatic pulse_period;
        period_end = 1'b1; step(1); period_end = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 out", pwm_out, pwm_in);
        chk("R12 flags", irq_flags, 2'b00);
        chk("R12 active", {1'b0, brake_active}, 2'b00);
    endtask

    task automatic t_cmp_edge;
        edge_en = 5'b00001;
        cmp_in[0] = 1'b1; step(1);
        braked("R1 cmp0 edge", 1);
        chk("R11 safe", pwm_out, 2'b10);
        cmp_in[0] = 1'b0; step(4);
        braked("R1 sticky", 1);
        chk("R10 edge flag", irq_flags, 2'b01);
        irq_ack = 2'b01; step(1); irq_ack = 2'b00;
        chk("R10 ack", irq_flags, 2'b00);
        edge_release = 1'b1; sw_edge_req = 1'b1; step(1);
        edge_release = 1'b0; sw_edge_req = 1'b0;
        braked("R2 clash", 1);
        irq_ack = 2'b01; sw_edge_req = 1'b1; step(1);
        irq_ack = 2'b00; sw_edge_req = 1'b0;
        chk("R10 set wins", irq_flags, 2'b01);
        step(3);
        braked("R6 sw edge held", 1);
        edge_release = 1'b1; step(1); edge_release = 1'b0;
        braked("R2 release", 0);
        irq_ack = 2'b01; step(1); irq_ack = 2'b00;
        edge_en = '0;
    endtask

    task automatic t_pin_level;
        nf_div = 3'd0; nf_count = 4'd3; level_en = 5'b00100;
        pin_raw[0] = 1'b1; step(3);
        braked("R8 not yet", 0);
        step(1);
        braked("R3 R8 pin level", 1);
        chk("R10 level flag", irq_flags, 2'b10);
        pin_raw[0] = 1'b0; step(10);
        braked("R3 wait boundary", 1);
        pulse_period;
        braked("R3 release", 0);
        pin_raw[0] = 1'b1; step(2); pin_raw[0] = 1'b0; step(10);
        braked("R8 glitch", 0);
        irq_ack = 2'b10; step(1); irq_ack = 2'b00;
        level_en = '0;
    endtask

    task automatic t_rearm;
        level_en = 5'b00010;
        cmp_in[1] = 1'b1; step(1);
        braked("R3 cmp1 level", 1);
        cmp_in[1] = 1'b0; step(2);
        cmp_in[1] = 1'b1; step(1);
        pulse_period;
        braked("R4 rearm", 1);
        cmp_in[1] = 1'b0; step(1); pulse_period;
        braked("R4 then release", 0);
        irq_ack = 2'b10; step(1); irq_ack = 2'b00;
        level_en = '0;
    endtask

    task automatic t_invert;
        pin_inv[1] = 1'b1; pin_raw[1] = 1'b1; step(8);
        level_en = 5'b01000; step(4);
        braked("R7 idle high", 0);
        pin_raw[1] = 1'b0; step(4);
        braked("R7 active low", 1);
        pin_raw[1] = 1'b1; step(8); pulse_period;
        braked("R7 release", 0);
        level_en = '0; irq_ack = 2'b10; step(1); irq_ack = 2'b00;
    endtask

    task automatic t_divider;
        nf_div = 3'd2; nf_count = 4'd2; level_en = 5'b00100;
        pin_raw[0] = 1'b1; step(4); pin_raw[0] = 1'b0; step(16);
        braked("R9 div4 reject", 0);
        nf_div = 3'd0;
        pin_raw[0] = 1'b1; step(4);
        braked("R9 div1 pass", 1);
        pin_raw[0] = 1'b0; step(8); pulse_period;
        nf_div = 3'd2;
        pin_raw[0] = 1'b1; step(20);
        braked("R9 div4 long", 1);
        pin_raw[0] = 1'b0; step(20); pulse_period;
        braked("R9 release", 0);
        level_en = '0; nf_div = 3'd0; irq_ack = 2'b10; step(1); irq_ack = 2'b00;
    endtask

    task automatic t_sys;
        level_en = 5'b10000; sys_fail_en = 4'b0010;
        sys_fail_in = 4'b0001; step(3);
        braked("R5 masked", 0);
        sys_fail_in = 4'b0011; step(1);
        braked("R5 brown-out", 1);
        sys_fail_in = 4'b0000; step(1); pulse_period;
        braked("R5 release", 0);
        level_en = '0; sys_fail_en = '0; irq_ack = 2'b10; step(1); irq_ack = 2'b00;
    endtask

    task automatic t_sw_level;
        safe_lvl = 2'b01; pwm_in = 2'b10;
        sw_level_req = 1'b1; step(1);
        chk("R6 R11 sw level", pwm_out, 2'b01);
        sw_level_req = 1'b0; step(1); pulse_period;
        chk("R11 pass", pwm_out, 2'b10);
    endtask

    initial begin
        step(3); rst_n = 1'b1; step(1);
        t_reset; t_cmp_edge; t_pin_level; t_rearm; t_invert;
        t_divider; t_sys; t_sw_level;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_err++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule